// File: doc/BRIEF.md
# Call and Interrupt Stack Sequencer

This block saves and restores processor context on a small circular stack held in the top 31 bytes of on-chip RAM. A single-cycle request starts one of four frame operations: a subroutine call, an interrupt entry, a return, or a return from interrupt. The sequencer then moves one byte per clock over a byte-wide RAM port and pulses `done` when the frame is complete.

A call frame holds only the 12-bit program counter, split into two bytes. An interrupt frame also holds the index register, the accumulator and the condition codes. The stack pointer moves downward on pushes and upward on pulls. It never leaves the window 0x061 to 0x07F; instead it wraps around. Restored values appear on dedicated outputs and stay there until a later pull replaces them.

The RAM read port is treated as asynchronous, so `mem_rdata` must reflect `mem_addr` within the same cycle. Instruction decode, the ALU and vector fetch sit outside this block.

Top module: `stack_seq`

## Requirements
- R1: After reset `sp_out` is 0x07F, `busy` and `done` are 0, and neither `mem_we` nor `mem_re` is asserted.
- R2: A call request accepted while idle writes `pc_in[7:0]` at address `sp` in the next cycle. In the cycle after that it writes the high byte at `sp-1`. The pointer is decremented after each byte, ending two below its starting value.
- R3: An interrupt request writes five bytes at descending addresses on consecutive cycles: PC low, PC high, index, accumulator, condition codes.
- R4: A return pulls two bytes, incrementing the pointer before each read. The PC high byte is read first and the PC low byte second, and `pc_out` is rebuilt from them.
- R5: A return from interrupt pulls condition codes, accumulator, index, PC high and PC low, in that order. It drives them to `cc_out`, `a_out`, `x_out` and `pc_out`.
- R6: A push at address 0x061 leaves the pointer at 0x07F. A pull with the pointer at 0x07F reads address 0x061 and leaves the pointer there.
- R7: The stored PC high byte carries 1s in bits 7:4. Those bits are ignored on a pull, so `pc_out[11:8]` comes only from bits 3:0 of the byte read.
- R8: `busy` is high during every byte-transfer cycle. `done` is a one-cycle pulse in the cycle after the last byte moves. Requests that arrive while busy are ignored.
- R9: When several requests are high in the same idle cycle, interrupt wins over call, call over return from interrupt, and return from interrupt over return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Start a subroutine-call push |
| irq_req | input | 1 | Start an interrupt-entry push |
| ret_req | input | 1 | Start a return pull |
| rti_req | input | 1 | Start a return-from-interrupt pull |
| pc_in | input | 12 | Program counter to save |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition codes to save |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_addr | output | 12 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, same cycle as address |
| pc_out | output | 12 | Restored program counter |
| x_out | output | 8 | Restored index register |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored condition codes |
| sp_out | output | 12 | Current stack pointer |
| busy | output | 1 | Frame transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step counter or a wrong slot mapping shows at once on the RAM port: an address or data byte is off in the very cycle it is driven. It also shows as a `done` pulse that arrives one cycle early or late. A pointer that wraps wrongly stays hidden until the stack crosses the 0x061 boundary. For that reason, long chains of nested calls are followed by returns, and each returned PC exposes any corruption within that frame's pull. Errors in the restore path appear on the restored-value outputs at the `done` cycle, including when a high PC byte has been planted with arbitrary upper bits.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_CALL = 3'd1,
        OP_IRQ  = 3'd2,
        OP_RET  = 3'd3,
        OP_RTI  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        SL_PCL = 3'd0,
        SL_PCH = 3'd1,
        SL_X   = 3'd2,
        SL_A   = 3'd3,
        SL_CC  = 3'd4
    } slot_e;

    localparam int SHORT_LEN = 2;
    localparam int LONG_LEN  = 5;
endpackage

// File: rtl/stack_ptr_step.sv
module stack_ptr_step #(
    parameter int AW = 12,
    parameter logic [AW-1:0] SP_TOP = 12'h07F,
    parameter logic [AW-1:0] SP_BOT = 12'h061
) (
    input  logic [AW-1:0] sp,
    output logic [AW-1:0] after_push,
    output logic [AW-1:0] pull_addr
);
    always_comb begin
        after_push = (sp == SP_BOT) ? SP_TOP : sp - AW'(1);
        pull_addr  = (sp == SP_TOP) ? SP_BOT : sp + AW'(1);
    end
endmodule

// File: rtl/frame_slot_map.sv
module frame_slot_map
    import stack_seq_pkg::*;
(
    input  op_e        op,
    input  logic [2:0] step,
    output slot_e      slot,
    output logic       is_push,
    output logic       last
);
    logic [2:0] len;
    logic [2:0] idx;

    always_comb begin
        is_push = (op == OP_CALL) || (op == OP_IRQ);
        len     = ((op == OP_CALL) || (op == OP_RET)) ? 3'(SHORT_LEN) : 3'(LONG_LEN);
        idx     = is_push ? step : (len - 3'd1 - step);
        slot    = slot_e'(idx);
        last    = (step == len - 3'd1);
    end
endmodule

// File: rtl/push_byte_sel.sv
module push_byte_sel
    import stack_seq_pkg::*;
#(
    parameter int PCW = 12,
    parameter int DW  = 8
) (
    input  slot_e          slot,
    input  logic [PCW-1:0] pc,
    input  logic [DW-1:0]  x,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  cc,
    output logic [DW-1:0]  data
);
    localparam int HI_W  = PCW - DW;
    localparam int PAD_W = DW - HI_W;

    always_comb begin
        unique case (slot)
            SL_PCL:  data = pc[DW-1:0];
            SL_PCH:  data = {{PAD_W{1'b1}}, pc[PCW-1:DW]};
            SL_X:    data = x;
            SL_A:    data = a;
            SL_CC:   data = cc;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int AW  = 12,
    parameter int PCW = 12,
    parameter int DW  = 8,
    parameter logic [AW-1:0] SP_TOP = 12'h07F,
    parameter logic [AW-1:0] SP_BOT = 12'h061
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_req,
    input  logic           irq_req,
    input  logic           ret_req,
    input  logic           rti_req,
    input  logic [PCW-1:0] pc_in,
    input  logic [DW-1:0]  x_in,
    input  logic [DW-1:0]  a_in,
    input  logic [DW-1:0]  cc_in,
    output logic           mem_we,
    output logic           mem_re,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [PCW-1:0] pc_out,
    output logic [DW-1:0]  x_out,
    output logic [DW-1:0]  a_out,
    output logic [DW-1:0]  cc_out,
    output logic [AW-1:0]  sp_out,
    output logic           busy,
    output logic           done
);
    localparam int HI_W = PCW - DW;

    typedef struct packed {
        logic           active;
        op_e            op;
        logic [2:0]     step;
        logic [AW-1:0]  sp;
        logic [PCW-1:0] cap_pc;
        logic [DW-1:0]  cap_x;
        logic [DW-1:0]  cap_a;
        logic [DW-1:0]  cap_cc;
        logic [PCW-1:0] rs_pc;
        logic [DW-1:0]  rs_x;
        logic [DW-1:0]  rs_a;
        logic [DW-1:0]  rs_cc;
        logic           done;
    } st_t;

    st_t st_d, st_q;

    slot_e          slot;
    logic           is_push;
    logic           last;
    logic [AW-1:0]  sp_after_push;
    logic [AW-1:0]  sp_pull_addr;
    logic [DW-1:0]  push_data;
    op_e            pick;

    frame_slot_map u_map (
        .op      (st_q.op),
        .step    (st_q.step),
        .slot    (slot),
        .is_push (is_push),
        .last    (last)
    );

    stack_ptr_step #(.AW(AW), .SP_TOP(SP_TOP), .SP_BOT(SP_BOT)) u_ptr (
        .sp         (st_q.sp),
        .after_push (sp_after_push),
        .pull_addr  (sp_pull_addr)
    );

    push_byte_sel #(.PCW(PCW), .DW(DW)) u_sel (
        .slot (slot),
        .pc   (st_q.cap_pc),
        .x    (st_q.cap_x),
        .a    (st_q.cap_a),
        .cc   (st_q.cap_cc),
        .data (push_data)
    );

    // Request arbitration: interrupt, call, return-from-interrupt, return (R9)
    always_comb begin
        if (irq_req)       pick = OP_IRQ;
        else if (call_req) pick = OP_CALL;
        else if (rti_req)  pick = OP_RTI;
        else if (ret_req)  pick = OP_RET;
        else               pick = OP_NONE;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = st_q.sp;
        mem_wdata = '0;

        if (!st_q.active) begin
            if (pick != OP_NONE) begin
                st_d.active = 1'b1;
                st_d.op     = pick;
                st_d.step   = '0;
                if ((pick == OP_CALL) || (pick == OP_IRQ)) begin
                    st_d.cap_pc = pc_in;
                    st_d.cap_x  = x_in;
                    st_d.cap_a  = a_in;
                    st_d.cap_cc = cc_in;
                end
            end
        end else begin
            if (is_push) begin
                // write then post-decrement
                mem_we    = 1'b1;
                mem_addr  = st_q.sp;
                mem_wdata = push_data;
                st_d.sp   = sp_after_push;
            end else begin
                // pre-increment then read
                mem_re   = 1'b1;
                mem_addr = sp_pull_addr;
                st_d.sp  = sp_pull_addr;
                unique case (slot)
                    SL_PCL:  st_d.rs_pc[DW-1:0]  = mem_rdata;
                    SL_PCH:  st_d.rs_pc[PCW-1:DW] = mem_rdata[HI_W-1:0];
                    SL_X:    st_d.rs_x  = mem_rdata;
                    SL_A:    st_d.rs_a  = mem_rdata;
                    SL_CC:   st_d.rs_cc = mem_rdata;
                    default: ;
                endcase
            end
            if (last) begin
                st_d.active = 1'b0;
                st_d.op     = OP_NONE;
                st_d.step   = '0;
                st_d.done   = 1'b1;
            end else begin
                st_d.step = st_q.step + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.op     <= OP_NONE;
            st_q.sp     <= SP_TOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_out = st_q.rs_pc;
    assign x_out  = st_q.rs_x;
    assign a_out  = st_q.rs_a;
    assign cc_out = st_q.rs_cc;
    assign sp_out = st_q.sp;
    assign busy   = st_q.active;
    assign done   = st_q.done;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
    parameter int AW = 12,
    parameter int DW = 8,
    parameter logic [AW-1:0] SP_TOP = 12'h07F,
    parameter logic [AW-1:0] SP_BOT = 12'h061
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] sp_out,
    input logic          busy,
    input logic          done
);
    // R8: RAM port is quiet whenever no transfer is in progress
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    // R8: done lasts exactly one cycle and follows a busy cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R2: reads and writes never coincide
    a_r2_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R6: pointer stays inside its window
    a_r6_sp_window: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_out >= SP_BOT) && (sp_out <= SP_TOP));

    // R2/R6: after a write the pointer sits one below the written address, wrapping
    a_r6_push_move: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == (($past(mem_addr) == SP_BOT) ? SP_TOP : $past(mem_addr) - AW'(1)));

    // R4/R6: a read targets the pre-incremented pointer and leaves it there
    a_r4_pull_move: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_out == $past(mem_addr));
    a_r6_pull_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr == ((sp_out == SP_TOP) ? SP_BOT : sp_out + AW'(1)));
endmodule

bind stack_seq stack_seq_chk #(.AW(AW), .DW(DW), .SP_TOP(SP_TOP), .SP_BOT(SP_BOT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp_out   (sp_out),
    .busy     (busy),
    .done     (done)
);

// File: tb/stack_seq_test.sv
module stack_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 0, irq_req = 0, ret_req = 0, rti_req = 0;
    logic [11:0] pc_in = '0;
    logic [7:0]  x_in = '0, a_in = '0, cc_in = '0;
    logic        mem_we, mem_re;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [11:0] pc_out, sp_out;
    logic [7:0]  x_out, a_out, cc_out;
    logic        busy, done;

    int compared = 0;
    int mismatched = 0;
    logic [11:0] esp = 12'h07F;
    logic [7:0]  ram [0:127];
    logic [11:0] pc_hist [0:63];

    always #5 clk = ~clk;

    stack_seq uut (
        .clk(clk), .rst_n(rst_n),
        .call_req(call_req), .irq_req(irq_req), .ret_req(ret_req), .rti_req(rti_req),
        .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .cc_out(cc_out),
        .sp_out(sp_out), .busy(busy), .done(done)
    );

    always @(posedge clk) if (mem_we) ram[mem_addr[6:0]] <= mem_wdata;
    assign mem_rdata = ram[mem_addr[6:0]];

    function automatic logic [11:0] dec_sp(input logic [11:0] s);
        return (s == 12'h061) ? 12'h07F : s - 12'd1;
    endfunction
    function automatic logic [11:0] inc_sp(input logic [11:0] s);
        return (s == 12'h07F) ? 12'h061 : s + 12'd1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Push a frame; extra request lines exercise arbitration (R9); noise tests R8.
    task automatic push_frame(input bit irq, input bit xcall, input bit xrti, input bit xret,
                              input logic [11:0] pc, input logic [7:0] x, input logic [7:0] a,
                              input logic [7:0] cc, input bit noise);
        logic [7:0] exp_b [0:4];
        int len;
        len = irq ? 5 : 2;
        exp_b[0] = pc[7:0];
        exp_b[1] = {4'hF, pc[11:8]};   // R7 padding
        exp_b[2] = x; exp_b[3] = a; exp_b[4] = cc;
        irq_req = irq; call_req = xcall; rti_req = xrti; ret_req = xret;
        pc_in = pc; x_in = x; a_in = a; cc_in = cc;
        @(negedge clk);
        irq_req = 0; call_req = 0; rti_req = 0; ret_req = 0;
        for (int k = 0; k < len; k++) begin
            chk(busy === 1'b1, "R8 busy during push", busy, 1);
            chk(mem_we === 1'b1 && mem_re === 1'b0, irq ? "R3 write strobe" : "R2 write strobe", mem_we, 1);
            chk(mem_addr === esp, irq ? "R3 push addr" : "R2 push addr", mem_addr, esp);
            chk(mem_wdata === exp_b[k], irq ? "R3 push data" : "R2 push data", mem_wdata, exp_b[k]);
            if (noise) begin
                ret_req = (k < len - 1);
                call_req = (k < len - 1);
            end
            esp = dec_sp(esp);
            @(negedge clk);
        end
        ret_req = 0; call_req = 0;
        chk(done === 1'b1 && busy === 1'b0, "R8 done after push", {busy, done}, 1);
        chk(sp_out === esp, "R2 R6 sp after push", sp_out, esp);
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", done, 0);
        chk(busy === 1'b0 && mem_we === 1'b0 && mem_re === 1'b0, "R8 ignored while busy",
            {busy, mem_we, mem_re}, 0);
    endtask

    task automatic pull_frame(input bit rti, input bit xret,
                              input logic [11:0] pc, input logic [7:0] x, input logic [7:0] a,
                              input logic [7:0] cc);
        int len;
        len = rti ? 5 : 2;
        rti_req = rti; ret_req = xret | !rti;
        @(negedge clk);
        rti_req = 0; ret_req = 0;
        for (int k = 0; k < len; k++) begin
            esp = inc_sp(esp);
            chk(mem_re === 1'b1 && mem_we === 1'b0, rti ? "R5 read strobe" : "R4 read strobe", mem_re, 1);
            chk(mem_addr === esp, rti ? "R5 pull addr" : "R4 R6 pull addr", mem_addr, esp);
            @(negedge clk);
        end
        chk(done === 1'b1, "R8 done after pull", done, 1);
        chk(sp_out === esp, "R4 sp after pull", sp_out, esp);
        chk(pc_out === pc, rti ? "R5 pc restore" : "R4 pc restore", pc_out, pc);
        if (rti) begin
            chk(x_out === x, "R5 x restore", x_out, x);
            chk(a_out === a, "R5 a restore", a_out, a);
            chk(cc_out === cc, "R5 cc restore", cc_out, cc);
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sp_out === 12'h07F, "R1 reset sp", sp_out, 12'h07F);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", {busy, done}, 0);
        chk(mem_we === 1'b0 && mem_re === 1'b0, "R1 reset port", {mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_out === 12'h07F && busy === 1'b0, "R1 idle after reset", sp_out, 12'h07F);

        // Sweep call/return over spread PC values (R2, R4)
        for (int i = 0; i < 48; i++) begin
            logic [11:0] p;
            p = 12'(i * 12'd347 + 12'd5);
            push_frame(0, 1, 0, 0, p, 8'h0, 8'h0, 8'h0, 0);
            pull_frame(0, 0, p, 8'h0, 8'h0, 8'h0);
        end

        // Interrupt/return-from-interrupt patterns (R3, R5)
        for (int i = 0; i < 24; i++) begin
            logic [11:0] p;
            logic [7:0] xv, av, cv;
            p = 12'(i * 12'd611 + 12'd9);
            xv = 8'(i * 37 + 1); av = 8'(i * 91 + 2); cv = 8'(i * 13 + 3);
            push_frame(1, 0, 0, 0, p, xv, av, cv, (i % 3) == 0);
            pull_frame(1, 0, p, xv, av, cv);
        end

        // Nested calls crossing the window bottom (R6), then LIFO returns
        for (int i = 0; i < 20; i++) begin
            pc_hist[i] = 12'(i * 12'd199 + 12'h0A3);
            push_frame(0, 1, 0, 0, pc_hist[i], 8'h0, 8'h0, 8'h0, 0);
        end
        for (int i = 19; i >= 5; i--) pull_frame(0, 0, pc_hist[i], 8'h0, 8'h0, 8'h0);

        // R7: arbitrary upper bits in a stored high byte are ignored
        for (int v = 0; v < 16; v++) begin
            logic [11:0] p;
            p = 12'(v * 12'h111 + 12'h02C);
            push_frame(0, 1, 0, 0, p, 8'h0, 8'h0, 8'h0, 0);
            ram[inc_sp(esp) & 12'h07F] = {4'(v ^ 4'h5), p[11:8]};
            pull_frame(0, 0, p, 8'h0, 8'h0, 8'h0);
        end

        // R9 arbitration
        push_frame(1, 1, 1, 1, 12'hABC, 8'h11, 8'h22, 8'h33, 0);    // irq wins
        push_frame(0, 1, 1, 1, 12'h5E7, 8'h0, 8'h0, 8'h0, 0);       // call beats pulls
        pull_frame(0, 0, 12'h5E7, 8'h0, 8'h0, 8'h0);
        pull_frame(1, 1, 12'hABC, 8'h11, 8'h22, 8'h33);             // rti beats ret

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule